// File: doc/BRIEF.md
# Dynamic Instruction Pair Grouper

This block sits between instruction fetch and the scheduler of a multi-pipeline signal processor. It accepts one tagged instruction per cycle and packs neighbouring instructions into packets of one or two slots. The only pairing it forms is a memory-access instruction immediately followed by an ALU instruction. Control-flow instructions, vector/SIMD instructions and compiler-formed groups always leave as packets of their own.

Completed packets go into a small FIFO. The scheduler drains that FIFO through a valid/ready port. Each packet carries a two-bit kind tag, so the splitter further down can tell a hardware-formed pair from a single instruction or from a group the compiler already built.

The grouper does no register-dependency check. When a pair turns out to be dependent, the splitter downstream issues its two halves one after the other.

Top module: `pair_grouper`

## Requirements
- R1: Class codes on `in_cls` are memory=0, ALU=1, control-flow=2, vector=3, static group=4, and 5 to 7 are reserved. A memory instruction whose next input arrives as an ALU instruction, with at most one idle input cycle between them, leaves as one packet with `out_tag`=1 (pair), the memory word in `out_slot0` and the ALU word in `out_slot1`.
- R2: A control-flow or reserved-class instruction leaves alone with `out_tag`=0 (single) and `out_slot1` zero. A pending memory instruction before it leaves first as its own single packet.
- R3: A vector instruction leaves alone with `out_tag`=0 and is never joined to a pending memory instruction.
- R4: Pairing does not depend on the instruction words. A memory/ALU pair whose words share register fields is still packed together.
- R5: A pending memory instruction waits at most one idle input cycle. After two consecutive idle input cycles it leaves alone with `out_tag`=0, and a later ALU instruction then travels as a single.
- R6: A static-group instruction (class 4) leaves alone with `out_tag`=2, its word in `out_slot0` and `out_slot1` zero.
- R7: Packets leave in program order, and slot 0 of a pair always holds the earlier instruction.
- R8: While `out_ready` is low the head packet stays on the outputs unchanged. Input is stalled rather than dropped, and no instruction is lost or reordered.
- R9: `q_full` is high exactly when QDEPTH packets are stored. While it is high, a non-memory input is refused (`in_ready` low).
- R10: Two memory instructions in a row produce a single packet for the first. The second may still pair with a following ALU instruction.
- R11: An ALU instruction with no pending memory instruction leaves alone with `out_tag`=0.
- R12: After reset `out_valid` and `q_full` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_cls | input | 3 | Instruction class code |
| in_word | input | IW | Instruction word |
| out_valid | output | 1 | Packet available |
| out_ready | input | 1 | Scheduler takes the packet |
| out_tag | output | 2 | 0 single, 1 dynamic pair, 2 static group |
| out_slot0 | output | IW | Earlier (or only) instruction |
| out_slot1 | output | IW | Later instruction of a pair, else zero |
| q_full | output | 1 | Packet FIFO holds QDEPTH entries |

## Verification
The bench builds the grouper with IW=16 and QDEPTH=2. With only two packet slots, backpressure fills the FIFO after two pushes. This brings the full flag, input refusal, and a memory instruction parked in the hold register during a stall all within a few cycles.

Idle gaps of zero, one and two cycles between a memory and an ALU instruction cover both sides of the one-cycle hold limit.

// File: rtl/pair_grouper.sv
module pair_grouper #(
  parameter int IW     = 32,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_cls,
  input  logic [IW-1:0] in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_tag,
  output logic [IW-1:0] out_slot0,
  output logic [IW-1:0] out_slot1,
  output logic          q_full
);
  localparam int AW = (QDEPTH > 2) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [1:0] K_SINGLE = 2'd0;
  localparam logic [1:0] K_PAIR   = 2'd1;
  localparam logic [1:0] K_STATIC = 2'd2;

  logic          hold_v, hold_age;
  logic [IW-1:0] hold_w;
  logic [1:0]    q_tag [QDEPTH];
  logic [IW-1:0] q_s0  [QDEPTH];
  logic [IW-1:0] q_s1  [QDEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  logic          push, pop, take, hold_load, hold_clr;
  logic [1:0]    p_tag;
  logic [IW-1:0] p_s0, p_s1;

  wire is_mem = (in_cls == 3'd0);
  wire is_alu = (in_cls == 3'd1);
  wire is_st  = (in_cls == 3'd4);
  wire full   = (cnt == CW'(QDEPTH));

  assign in_ready  = hold_v ? (!full && (is_mem || is_alu)) : (is_mem || !full);
  assign take      = in_valid && in_ready;
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign q_full    = full;
  assign out_tag   = q_tag[rp];
  assign out_slot0 = q_s0[rp];
  assign out_slot1 = q_s1[rp];

  always_comb begin
    push      = 1'b0;
    hold_load = 1'b0;
    hold_clr  = 1'b0;
    p_tag     = K_SINGLE;
    p_s0      = in_word;
    p_s1      = '0;
    if (hold_v) begin
      if (in_valid && !full) begin
        push = 1'b1;
        p_s0 = hold_w;
        if (is_alu) begin
          p_tag    = K_PAIR;
          p_s1     = in_word;
          hold_clr = 1'b1;
        end else if (is_mem) begin
          hold_load = 1'b1;
        end else begin
          hold_clr = 1'b1;
        end
      end else if (!in_valid && hold_age && !full) begin
        push     = 1'b1;
        p_s0     = hold_w;
        hold_clr = 1'b1;
      end
    end else if (take) begin
      if (is_mem) hold_load = 1'b1;
      else begin
        push  = 1'b1;
        p_tag = is_st ? K_STATIC : K_SINGLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_age <= 1'b0;
      hold_w   <= '0;
    end else if (hold_load) begin
      hold_v   <= 1'b1;
      hold_age <= 1'b0;
      hold_w   <= in_word;
    end else if (hold_clr) begin
      hold_v   <= 1'b0;
      hold_age <= 1'b0;
    end else if (hold_v && !in_valid) begin
      hold_age <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        q_tag[wp] <= p_tag;
        q_s0[wp]  <= p_s0;
        q_s1[wp]  <= p_s1;
        wp <= (wp == AW'(QDEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(QDEPTH)); // R9
  AST_FULL_HAS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> out_valid); // R9
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && hold_age && !in_valid && !full |=> !hold_v); // R5
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_slot0) && $stable(out_slot1)); // R8
  AST_SINGLE_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tag != K_PAIR |-> out_slot1 == '0); // R2
  AST_LONE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_cls == 3'd2 || in_cls == 3'd3) |-> !hold_v); // R3
endmodule

// File: tb/sim_pair_grouper.sv
module sim_pair_grouper;
  localparam int IW = 16;
  localparam int QD = 2;
  localparam int EW = 2 + 2 * IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_cls = 3'd1;
  logic [IW-1:0] in_word = '0;
  logic in_ready, out_valid, q_full;
  logic [1:0] out_tag;
  logic [IW-1:0] out_slot0, out_slot1;

  int checks = 0, fails = 0;
  logic [EW-1:0] exp_q[$];
  string exp_r[$];
  logic pend_v = 1'b0;
  logic [IW-1:0] pend_w = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pair_grouper #(.IW(IW), .QDEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .out_slot0(out_slot0),
    .out_slot1(out_slot1), .q_full(q_full));

  task automatic check(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  task automatic expect_pkt(input logic [1:0] t, input logic [IW-1:0] a, input logic [IW-1:0] b, input string req);
    exp_q.push_back({t, a, b});
    exp_r.push_back(req);
  endtask

  task automatic send(input logic [2:0] c, input logic [IW-1:0] w, input int gap, input string req);
    if (pend_v && gap >= 2) begin
      expect_pkt(2'd0, pend_w, '0, "R5");
      pend_v = 1'b0;
    end
    if (pend_v) begin
      if (c == 3'd1) begin
        expect_pkt(2'd1, pend_w, w, req);
        pend_v = 1'b0;
      end else if (c == 3'd0) begin
        expect_pkt(2'd0, pend_w, '0, "R10");
        pend_w = w;
      end else begin
        expect_pkt(2'd0, pend_w, '0, req);
        pend_v = 1'b0;
        expect_pkt((c == 3'd4) ? 2'd2 : 2'd0, w, '0, req);
      end
    end else if (c == 3'd0) begin
      pend_v = 1'b1;
      pend_w = w;
    end else begin
      expect_pkt((c == 3'd4) ? 2'd2 : 2'd0, w, '0, req);
    end
    repeat (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_cls   = c;
    in_word  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    if (pend_v && n >= 2) begin
      expect_pkt(2'd0, pend_w, '0, "R5");
      pend_v = 1'b0;
    end
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", {out_tag, out_slot0, out_slot1}, '0);
        end else begin
          check({out_tag, out_slot0, out_slot1} == exp_q[0], exp_r[0],
                {out_tag, out_slot0, out_slot1}, exp_q[0]);
          void'(exp_q.pop_front());
          void'(exp_r.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && !q_full && in_ready, "R12", {out_valid, q_full, in_ready}, 3'b001);

    send(3'd0, 16'h1001, 0, "R1");
    send(3'd1, 16'h2001, 0, "R1");
    send(3'd0, 16'h1002, 0, "R1");
    send(3'd1, 16'h2002, 1, "R1");
    send(3'd0, 16'h1234, 0, "R4");
    send(3'd1, 16'h1234, 0, "R4");
    send(3'd0, 16'h1003, 0, "R5");
    send(3'd1, 16'h2003, 2, "R11");
    send(3'd0, 16'h1004, 0, "R2");
    send(3'd2, 16'h3004, 0, "R2");
    send(3'd2, 16'h3005, 0, "R2");
    send(3'd5, 16'h3006, 0, "R2");
    send(3'd0, 16'h1007, 0, "R3");
    send(3'd3, 16'h4007, 0, "R3");
    send(3'd3, 16'h4008, 0, "R3");
    send(3'd4, 16'h5009, 0, "R6");
    send(3'd0, 16'h100a, 0, "R6");
    send(3'd4, 16'h500a, 0, "R6");
    send(3'd1, 16'h200b, 0, "R11");
    send(3'd0, 16'h100c, 0, "R10");
    send(3'd0, 16'h100d, 0, "R10");
    send(3'd1, 16'h200d, 0, "R10");
    idle(4);

    out_ready = 1'b0;
    send(3'd2, 16'h300e, 0, "R8");
    send(3'd2, 16'h300f, 0, "R8");
    idle(1);
    @(negedge clk);
    #1;
    check(q_full, "R9", {33'd0, q_full}, 1);
    held = out_slot0;
    in_valid = 1'b1;
    in_cls   = 3'd1;
    in_word  = 16'h2fff;
    #0.5;
    check(!in_ready, "R9", {33'd0, in_ready}, 0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid && out_slot0 == held && out_tag == 2'd0, "R8", {out_tag, out_slot0, 16'd0}, {2'd0, held, 16'd0});
    send(3'd0, 16'h1010, 0, "R8");
    fork
      begin
        repeat (3) @(negedge clk);
        out_ready = 1'b1;
      end
      send(3'd1, 16'h2010, 0, "R8");
    join
    send(3'd0, 16'h1011, 0, "R5");
    idle(6);
    @(negedge clk);
    #1;
    check(!q_full, "R9", {33'd0, q_full}, 0);
    check(exp_q.size() == 0, "R7", EW'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule